// File: doc/BRIEF.md
# Clock Generator Control Register Target

This block is the two-wire serial control port of a multi-output clock generator. A host controller addresses it on an I2C-style bus. It holds eight byte-wide registers that set which clock outputs run, where the frequency code comes from and what its value is, the spread-spectrum mode, and the skew between the memory and processor clocks. The frequency tables, synthesis loops and pad drivers sit elsewhere. This block only supplies their control bits.

A write transfer carries the device address, one command byte and one count byte. The block acknowledges both of these bytes and then discards their contents. After them, each data byte lands in the next register, starting at register 0. A read transfer first returns the fixed register count and then the eight registers in order. Some bits are read-only. Some show the frequency strap pins, which are captured during reset. Two whole registers hold a fixed identity. SCL and SDA are sampled by a system clock that runs much faster than SCL. The SDA line is open-drain, so the block pulls it low through an output-enable.

Top module: `clkctl_i2c_regs`

## Requirements
- R1: While rst_n is low, the registers take their defaults. Registers 0, 1 and 2 become 0xFF. The writable bits of register 3 (6, 5, 3, 2, 1) become 1. Register 4 becomes 0x00. Register 5 becomes 0x40, which gives spread off, the narrow spread amount and skew code 100. sda_oe is 0.
- R2: The block acknowledges an address byte whose upper seven bits equal DEV_ADDR (default 0x69), and bit 0 of that byte selects read (1) or write (0). For any other address it gives no acknowledge and ignores the bus until the next START.
- R3: In a write transfer, the first two bytes after the address are the command byte and the count byte. Both are acknowledged and neither changes any register.
- R4: The data bytes after the count byte are written to register 0, 1, 2 and so on, and each is acknowledged. Bytes aimed at register index 8 and above are also acknowledged, and they are discarded.
- R5: The following bits are read-only, and writes to them have no effect:
  - Register 3 bits 7, 4 and 0 read as the inverses of latched straps FS0, FS1 and FS2.
  - Register 5 bits 3 and 2 read as the inverses of latched straps FS3 and FS4.
  - Register 4 bit 0 and register 5 bit 0 read as 0.
- R6: Register 6 always reads 0x98 and register 7 always reads 0x31, and writes to either are ignored.
- R7: A read transfer returns 0x08 first, then registers 0 to 7. Any byte after those reads 0xFF. When the host answers a byte with a NACK, sda_oe is released and the transfer ends. No register changes during a read.
- R8: Every START, including a repeated START, sets both the write index and the read index back to the beginning.
- R9: If register 4 bit 3 is 1, freq_code is {r4[1], r4[2], r4[7:4]}. If it is 0, freq_code is {0, latched FS4..FS0}.
- R10: fs_strap is captured only while rst_n is low. Any change on fs_strap after reset affects neither freq_code nor the readback.
- R11: The outputs follow the registers:
  - en_a, en_b and en_c equal registers 0, 1 and 2.
  - en_d equals {r3[6], r3[5], r3[3], r3[2], r3[1]}.
  - spread_wide equals r5[7], skew_code equals r5[6:4] and spread_en equals r5[1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low power-up reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| fs_strap | input | 5 | Frequency strap levels FS4..FS0 |
| sda_oe | output | 1 | 1 pulls SDA low |
| en_a | output | 8 | Enables for clock group A (register 0) |
| en_b | output | 8 | Enables for clock group B (register 1) |
| en_c | output | 8 | Enables for clock group C (register 2) |
| en_d | output | 5 | Enables for miscellaneous clocks (register 3) |
| freq_code | output | 6 | Effective frequency select code |
| spread_wide | output | 1 | 1 selects the wider spread amount |
| spread_en | output | 1 | Spread-spectrum enable |
| skew_code | output | 3 | Memory-to-processor skew code |

## Verification
The assertions rely on a well-formed bus:
- SCL is slow enough that every level lasts several system clocks.
- SDA changes only while SCL is low, except for START and STOP.
- fs_strap is settled before reset is released.

The stimulus keeps to these rules. It drives SCL with 5-cycle quarter periods and moves SDA one quarter after each SCL fall. It offsets every input change from the system clock edge, and it models the bus as a wired-AND of the host and the block. The strap pins are set during reset and changed only after reset, which exercises the capture rule.

// File: rtl/clkctl_i2c_regs.sv
module clkctl_i2c_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] ID_HI    = 8'h98,
  parameter logic [7:0] ID_LO    = 8'h31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [4:0] fs_strap,
  output logic       sda_oe,
  output logic [7:0] en_a,
  output logic [7:0] en_b,
  output logic [7:0] en_c,
  output logic [4:0] en_d,
  output logic [5:0] freq_code,
  output logic       spread_wide,
  output logic       spread_en,
  output logic [2:0] skew_code
);
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX} st_t;

  localparam int NREG = 8;
  localparam logic [47:0] CFG_RST   = {8'h40, 8'h00, 8'h6E, 8'hFF, 8'hFF, 8'hFF};
  localparam logic [47:0] CFG_WMASK = {8'hF2, 8'hFE, 8'h6E, 8'hFF, 8'hFF, 8'hFF};

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic [4:0] strap_q;
  logic [5:0][7:0] cfg;
  logic [7:0][7:0] view;
  st_t        state;
  logic [3:0] bitcnt, widx, ridx;
  logic [7:0] shreg, txsh;
  logic       first, rw, mnack;

  wire scl = scl_sy[1];
  wire sda = sda_sy[1];
  wire scl_rise = scl & ~scl_d;
  wire scl_fall = ~scl & scl_d;
  wire start_c  = scl & scl_d & sda_d & ~sda;
  wire stop_c   = scl & scl_d & ~sda_d & sda;
  wire [3:0] ridx_n = (ridx == 4'hF) ? ridx : ridx + 4'd1;

  function automatic logic [7:0] pick(input logic [3:0] i, input logic [63:0] v);
    if (i == 4'd0) return 8'(NREG);
    else if (i <= 4'(NREG)) return v[{i - 4'd1, 3'b000} +: 8];
    else return 8'hFF;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i}; sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl; sda_d <= sda;
    end

  always_ff @(posedge clk)
    if (!rst_n) strap_q <= fs_strap;

  always_comb begin
    view[0] = cfg[0];
    view[1] = cfg[1];
    view[2] = cfg[2];
    view[3] = cfg[3] | {~strap_q[0], 2'b00, ~strap_q[1], 3'b000, ~strap_q[2]};
    view[4] = cfg[4];
    view[5] = cfg[5] | {4'b0000, ~strap_q[3], ~strap_q[4], 2'b00};
    view[6] = ID_HI;
    view[7] = ID_LO;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_IDLE; bitcnt <= '0; widx <= '0; ridx <= '0;
      shreg <= '0; txsh <= '0; first <= 1'b0; rw <= 1'b0; mnack <= 1'b0;
      sda_oe <= 1'b0; cfg <= CFG_RST;
    end else if (start_c) begin
      state <= ST_RX; bitcnt <= '0; widx <= '0; ridx <= '0;
      first <= 1'b1; sda_oe <= 1'b0;
    end else if (stop_c) begin
      state <= ST_IDLE; sda_oe <= 1'b0;
    end else if (state == ST_RX) begin
      if (scl_rise && bitcnt < 4'd8) begin
        shreg  <= {shreg[6:0], sda};
        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall && bitcnt == 4'd8) begin
        if (first) begin
          if (shreg[7:1] == DEV_ADDR) begin
            sda_oe <= 1'b1; rw <= shreg[0]; bitcnt <= 4'd9;
          end else state <= ST_IDLE;
        end else begin
          sda_oe <= 1'b1; bitcnt <= 4'd9;
          if (widx >= 4'd2 && widx < 4'd8)
            cfg[widx - 4'd2] <= shreg & CFG_WMASK[{widx - 4'd2, 3'b000} +: 8];
          if (widx != 4'hF) widx <= widx + 4'd1;
        end
      end else if (scl_fall && bitcnt == 4'd9) begin
        bitcnt <= '0; first <= 1'b0;
        if (first && rw) begin
          state  <= ST_TX;
          txsh   <= pick(ridx, view);
          sda_oe <= ~pick(ridx, view)[7];
        end else sda_oe <= 1'b0;
      end
    end else if (state == ST_TX) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) bitcnt <= bitcnt + 4'd1;
        else if (bitcnt == 4'd8) begin mnack <= sda; bitcnt <= 4'd9; end
      end else if (scl_fall) begin
        if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
          txsh <= {txsh[6:0], 1'b0}; sda_oe <= ~txsh[6];
        end else if (bitcnt == 4'd8) sda_oe <= 1'b0;
        else if (bitcnt == 4'd9) begin
          if (mnack) begin state <= ST_IDLE; sda_oe <= 1'b0; end
          else begin
            ridx <= ridx_n; txsh <= pick(ridx_n, view);
            sda_oe <= ~pick(ridx_n, view)[7]; bitcnt <= '0;
          end
        end
      end
    end

  assign en_a        = cfg[0];
  assign en_b        = cfg[1];
  assign en_c        = cfg[2];
  assign en_d        = {cfg[3][6], cfg[3][5], cfg[3][3], cfg[3][2], cfg[3][1]};
  assign freq_code   = cfg[4][3] ? {cfg[4][1], cfg[4][2], cfg[4][7:4]} : {1'b0, strap_q};
  assign spread_wide = cfg[5][7];
  assign skew_code   = cfg[5][6:4];
  assign spread_en   = cfg[5][1];

  AST_TX_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX) |=> $stable(cfg)); // R7
  AST_HW_CODE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[4][3] |-> (freq_code[5] == 1'b0)); // R9
  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(strap_q)); // R10
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R2
  AST_START_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (widx == 4'd0 && ridx == 4'd0)); // R8
endmodule

// File: tb/test_clkctl_i2c_regs.sv
module test_clkctl_i2c_regs;
  localparam int Q = 40;
  localparam logic [6:0] ADDR = 7'h69;
  localparam logic [4:0] STRAP = 5'b10110;
  localparam logic [47:0] VEC [4] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF},
    {8'h81, 8'h5C, 8'hC3, 8'h3C, 8'h5A, 8'hA5},
    {8'hE3, 8'h96, 8'h78, 8'h56, 8'h34, 8'h12}};

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic [4:0] fs_strap = STRAP;
  logic sda_oe, spread_wide, spread_en;
  logic [7:0] en_a, en_b, en_c;
  logic [4:0] en_d;
  logic [5:0] freq_code;
  logic [2:0] skew_code;
  wire sda_line = sda_m & ~sda_oe;
  int checks = 0, fails = 0;

  clkctl_i2c_regs i_clkctl_i2c_regs (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .fs_strap(fs_strap), .sda_oe(sda_oe), .en_a(en_a), .en_b(en_b), .en_c(en_c), .en_d(en_d),
    .freq_code(freq_code), .spread_wide(spread_wide), .spread_en(spread_en), .skew_code(skew_code));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(150000 * 8);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  task automatic bstart(); sda_m = 1; #Q; scl_m = 1; #(2*Q); sda_m = 0; #(2*Q); scl_m = 0; #Q; endtask
  task automatic bstop();  sda_m = 0; #Q; scl_m = 1; #(2*Q); sda_m = 1; #(2*Q); endtask
  task automatic put_bit(input logic b); sda_m = b; #Q; scl_m = 1; #(2*Q); scl_m = 0; #Q; endtask
  task automatic get_bit(output logic b);
    sda_m = 1; #Q; scl_m = 1; #Q; b = sda_line; #Q; scl_m = 0; #Q;
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b); ack = !b;
  endtask
  task automatic rbyte(output logic [7:0] d, input logic nack);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(nack);
  endtask

  function automatic logic [7:0] expv(input logic [47:0] w, input int k);
    case (k)
      0: return 8'h08;
      1, 2, 3: return w[8*(k-1) +: 8];
      4: return (w[31:24] & 8'h6E) | {~STRAP[0], 2'b0, ~STRAP[1], 3'b0, ~STRAP[2]};
      5: return w[39:32] & 8'hFE;
      6: return (w[47:40] & 8'hF2) | {4'b0, ~STRAP[3], ~STRAP[4], 2'b0};
      7: return 8'h98;
      8: return 8'h31;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic rd_seq(input int n, input logic [47:0] w, input string tag);
    logic ack; logic [7:0] d;
    bstart(); wbyte({ADDR, 1'b1}, ack); chk({tag, " R2 read addr ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(d, k == n - 1);
      chk($sformatf("%s R7 read byte %0d", tag, k), d, expv(w, k));
    end
    #(3*Q); chk({tag, " R7 released after nack"}, sda_oe, 0);
    bstop();
  endtask

  task automatic chk_outs(input logic [47:0] w, input string tag);
    logic [5:0] fc;
    fc = w[35] ? {w[33], w[34], w[39:36]} : {1'b0, STRAP};
    chk({tag, " R11 en_a"}, en_a, w[7:0]);
    chk({tag, " R11 en_b"}, en_b, w[15:8]);
    chk({tag, " R11 en_c"}, en_c, w[23:16]);
    chk({tag, " R11 en_d"}, en_d, {w[30], w[29], w[27], w[26], w[25]});
    chk({tag, " R11 spread_wide"}, spread_wide, w[47]);
    chk({tag, " R11 skew"}, skew_code, w[46:44]);
    chk({tag, " R11 spread_en"}, spread_en, w[41]);
    chk({tag, " R9 freq_code"}, freq_code, fc);
  endtask

  initial begin
    logic ack;
    logic [47:0] cur;
    repeat (5) @(posedge clk);
    #1;
    chk("R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    fs_strap = 5'b01001;  // R10: change after reset must be ignored
    cur = {8'h40, 8'h00, 8'h6E, 8'hFF, 8'hFF, 8'hFF};
    chk_outs(cur, "R1 reset");
    chk("R10 freq_code keeps latched straps", freq_code, {1'b0, STRAP});
    rd_seq(9, cur, "R1 R5 R6 reset readback");

    foreach (VEC[v]) begin
      bstart();
      wbyte({ADDR, 1'b0}, ack); chk("R2 write addr ack", ack, 1);
      wbyte(8'h07, ack); chk("R3 command ack", ack, 1);
      wbyte(8'h01, ack); chk("R3 count ack", ack, 1);
      for (int k = 0; k < 6; k++) begin
        wbyte(VEC[v][8*k +: 8], ack); chk("R4 data ack", ack, 1);
      end
      wbyte(8'h00, ack); chk("R6 id write ack", ack, 1);
      wbyte(8'hFF, ack); chk("R6 id write ack", ack, 1);
      wbyte(8'hC4, ack); chk("R4 extra byte ack", ack, 1);
      bstop();
      #(2*Q);
      chk_outs(VEC[v], $sformatf("R4 vec%0d", v));
      rd_seq(11, VEC[v], $sformatf("R5 R6 vec%0d", v));
      cur = VEC[v];
    end

    bstart();
    wbyte({7'h2A, 1'b0}, ack); chk("R2 foreign address not acked", ack, 0);
    wbyte(8'h00, ack); wbyte(8'h00, ack); wbyte(8'hAB, ack);
    bstop(); #(2*Q);
    chk("R2 foreign write ignored en_a", en_a, cur[7:0]);

    bstart();
    wbyte({ADDR, 1'b0}, ack); wbyte(8'h05, ack); wbyte(8'h01, ack);
    wbyte(8'h11, ack); wbyte(8'h22, ack);
    bstart();
    wbyte({ADDR, 1'b0}, ack); wbyte(8'h02, ack); wbyte(8'h02, ack);
    wbyte(8'h33, ack); chk("R8 ack after repeated start", ack, 1);
    bstop(); #(2*Q);
    chk("R8 repeated start restarts at reg0", en_a, 8'h33);
    chk("R4 second byte to reg1", en_b, 8'h22);
    chk("R3 command byte selects nothing en_c", en_c, cur[23:16]);
    chk("R3 command byte selects nothing skew", skew_code, cur[46:44]);
    cur[15:0] = 16'h2233;
    rd_seq(1, cur, "R7 early nack");
    rd_seq(3, cur, "R8 read restarts");
    summary();
  end
endmodule